// File: doc/BRIEF.md
# Counter Clock Source Selector

This block feeds the clock input of every channel in a set of counter groups (by default two groups of three channels). Each channel holds a small source code, written and read back over a simple register port. The code picks what that channel counts: its own clock pin, one of five decade rates derived from the 20 MHz system clock, the output of the channel before it on a ring that crosses group boundaries, the external clock shared within its group, or, in extended mode, a fixed level, a pattern-detect signal or the full 20 MHz rate.

The selected source becomes one single-cycle clock-enable pulse per counting event, so the counters run entirely on the system clock. Level sources are counted on their rising edges. Asynchronous pins pass through a two-flop synchronizer first. Whenever a channel is not counting its own pin, that pin becomes an output and drives the selected clock.

Top module: `ccs_clk_select`

## Requirements
- R1: While reset is asserted and right after it, every source code is 0, every clk_en bit is 0 and every clk_pin_oe bit is 0.
- R2: A write with wr_chan below the channel count stores the 5-bit wr_data into that channel, and rd_data returns it unchanged. A write to a higher index changes no channel, and reading such an index returns 0.
- R3: Code 0 counts the channel's own pin. Each rising edge of clk_pin_in gives exactly one clk_en pulse, a steady level gives none, and clk_pin_oe stays 0.
- R4: Any nonzero code sets clk_pin_oe, and clk_pin_out then carries the selected source level. For an internal rate this is the rate strobe.
- R5: Codes 1 to 5 give clk_en pulses with periods of 2, 20, 200, 2000 and 20000 system cycles (10 MHz down to 1 kHz from a 20 MHz clock). Each pulse is one cycle wide.
- R6: Code 6 counts rising edges of cnt_out of the preceding channel. Channel k>0 of a group uses channel k-1. Channel 0 uses the last channel of the previous group, and group 0 takes it from the last group.
- R7: Code 7 counts rising edges of the external clock of the channel's own group, which all channels of that group share.
- R8: With ext_mode=1, code 8 is a constant high and code 9 a constant low, and neither produces pulses. Code 10 counts rising edges of pattern_in, and code 11 gives a pulse every cycle.
- R9: With ext_mode=0, codes 8 to 31 select a constant low. With ext_mode=1, codes 12 to 31 also select a constant low. None of them produces pulses.
- R10: clk_en never stays high for two consecutive cycles unless the 20 MHz source is selected or the code has just changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 20 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | Enables the extended source codes 8 to 11 |
| wr_en | input | 1 | Write strobe for a source code |
| wr_chan | input | CHAN_W | Channel index of the write |
| wr_data | input | 5 | Source code to store |
| rd_chan | input | CHAN_W | Channel index of the read |
| rd_data | output | 5 | Stored code of rd_chan |
| clk_pin_in | input | NUM_GRP*CH_PER_GRP | Per-channel clock pin, input side |
| ext_clk_in | input | NUM_GRP | Shared external clock per group |
| pattern_in | input | 1 | Pattern-present signal |
| cnt_out | input | NUM_GRP*CH_PER_GRP | Counter outputs, used as ring sources |
| clk_en | output | NUM_GRP*CH_PER_GRP | One-cycle clock-enable pulse per channel |
| clk_pin_oe | output | NUM_GRP*CH_PER_GRP | Per-channel clock pin output enable |
| clk_pin_out | output | NUM_GRP*CH_PER_GRP | Per-channel clock pin drive value |

## Verification
Several properties are checked on every cycle. The decade strobes must nest, each slower strobe landing on a faster one, and the fastest strobe must never repeat on back-to-back cycles. A channel held at a fixed level must stay quiet. Enable pulses must be single-cycle apart from the 20 MHz source. Writes must land only in the addressed channel, and a nonzero code must always turn its pin into an output. Only the bench's scenarios can show the exact rate periods, the ring wiring across the group boundary, the sharing of the external clock, the synchronizer-delayed pin edges and the mode-dependent treatment of the upper codes.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int CODE_W    = 5;
  localparam int NUM_RATES = 5;

  localparam logic [CODE_W-1:0] C_PIN  = 5'd0;
  localparam logic [CODE_W-1:0] C_RING = 5'd6;
  localparam logic [CODE_W-1:0] C_EXT  = 5'd7;
  localparam logic [CODE_W-1:0] C_HIGH = 5'd8;
  localparam logic [CODE_W-1:0] C_LOW  = 5'd9;
  localparam logic [CODE_W-1:0] C_PAT  = 5'd10;
  localparam logic [CODE_W-1:0] C_BASE = 5'd11;

  typedef enum logic [2:0] {
    K_PIN, K_RATE, K_RING, K_EXT, K_HIGH, K_LOW, K_PAT, K_BASE
  } src_kind_e;

  function automatic src_kind_e decode_src(input logic [CODE_W-1:0] code,
                                           input logic ext);
    src_kind_e k;
    k = K_LOW;
    if (code == C_PIN)                       k = K_PIN;
    else if (code <= CODE_W'(NUM_RATES))     k = K_RATE;
    else if (code == C_RING)                 k = K_RING;
    else if (code == C_EXT)                  k = K_EXT;
    else if (ext) begin
      case (code)
        C_HIGH:  k = K_HIGH;
        C_LOW:   k = K_LOW;
        C_PAT:   k = K_PAT;
        C_BASE:  k = K_BASE;
        default: k = K_LOW;
      endcase
    end
    return k;
  endfunction
endpackage

// File: rtl/ccs_sync.sv
module ccs_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/ccs_prescaler.sv
module ccs_prescaler #(
  parameter int BASE_DIV  = 2,
  parameter int DECADES   = 4,
  parameter int DEC_RATIO = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [DECADES:0] rate_stb
);
  localparam int BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam int DW = $clog2(DEC_RATIO);

  logic [BW-1:0] base_q, base_d;

  always_comb begin
    rate_stb[0] = (base_q == BW'(BASE_DIV-1));
    base_d      = rate_stb[0] ? '0 : base_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  p_fast_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rate_stb[0] |=> !rate_stb[0]);

  for (genvar i = 1; i <= DECADES; i++) begin : g_dec
    logic [DW-1:0] dec_q, dec_d;
    logic          wrap;

    always_comb begin
      wrap        = (dec_q == DW'(DEC_RATIO-1));
      rate_stb[i] = rate_stb[i-1] && wrap;
      dec_d       = dec_q;
      if (rate_stb[i-1]) dec_d = wrap ? '0 : dec_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dec_q <= '0;
      else        dec_q <= dec_d;
    end

    p_nested_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rate_stb[i] |-> rate_stb[i-1]);
  end
endmodule

// File: rtl/ccs_chan_sel.sv
module ccs_chan_sel
  import ccs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CODE_W-1:0]    code,
  input  logic                 ext_mode,
  input  logic [NUM_RATES-1:0] rate_stb,
  input  logic                 pin_lvl,
  input  logic                 ring_lvl,
  input  logic                 ext_lvl,
  input  logic                 pat_lvl,
  output logic                 clk_en,
  output logic                 pin_oe,
  output logic                 pin_out
);
  src_kind_e  kind;
  logic [7:0] rate_pad;
  logic [2:0] ridx;
  logic       lvl, lvl_q, tick, en_q;

  always_comb begin
    kind     = decode_src(code, ext_mode);
    rate_pad = 8'(rate_stb);
    ridx     = code[2:0] - 3'd1;
    case (kind)
      K_PIN:   lvl = pin_lvl;
      K_RATE:  lvl = rate_pad[ridx];
      K_RING:  lvl = ring_lvl;
      K_EXT:   lvl = ext_lvl;
      K_HIGH:  lvl = 1'b1;
      K_PAT:   lvl = pat_lvl;
      K_BASE:  lvl = 1'b1;
      default: lvl = 1'b0;
    endcase
    case (kind)
      K_RATE:        tick = rate_pad[ridx];
      K_BASE:        tick = 1'b1;
      K_HIGH, K_LOW: tick = 1'b0;
      default:       tick = lvl & ~lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      lvl_q <= lvl;
      en_q  <= tick;
    end
  end

  assign clk_en  = en_q;
  assign pin_oe  = (kind != K_PIN);
  assign pin_out = pin_oe & lvl;

  p_level_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_LOW || kind == K_HIGH) |=> !clk_en);

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && $past(clk_en)) |->
      ($past(kind) == K_BASE || $past(kind) != $past(kind, 2)));
endmodule

// File: rtl/ccs_clk_select.sv
module ccs_clk_select
  import ccs_pkg::*;
#(
  parameter int NUM_GRP    = 2,
  parameter int CH_PER_GRP = 3,
  parameter int CHAN_W     = $clog2(NUM_GRP*CH_PER_GRP),
  parameter int BASE_DIV   = 2,
  parameter int DEC_RATIO  = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ext_mode,
  input  logic                           wr_en,
  input  logic [CHAN_W-1:0]              wr_chan,
  input  logic [CODE_W-1:0]              wr_data,
  input  logic [CHAN_W-1:0]              rd_chan,
  output logic [CODE_W-1:0]              rd_data,
  input  logic [NUM_GRP*CH_PER_GRP-1:0]  clk_pin_in,
  input  logic [NUM_GRP-1:0]             ext_clk_in,
  input  logic                           pattern_in,
  input  logic [NUM_GRP*CH_PER_GRP-1:0]  cnt_out,
  output logic [NUM_GRP*CH_PER_GRP-1:0]  clk_en,
  output logic [NUM_GRP*CH_PER_GRP-1:0]  clk_pin_oe,
  output logic [NUM_GRP*CH_PER_GRP-1:0]  clk_pin_out
);
  localparam int NUM_CH  = NUM_GRP * CH_PER_GRP;
  localparam int SYNC_W  = NUM_CH + NUM_GRP + 1;
  localparam int DECADES = NUM_RATES - 1;

  logic [NUM_CH-1:0][CODE_W-1:0] code_q, code_d;
  logic                          wr_ok, rd_ok;
  logic [SYNC_W-1:0]             sync_q;
  logic [NUM_CH-1:0]             pin_s;
  logic [NUM_GRP-1:0]            ext_s;
  logic                          pat_s;
  logic [NUM_RATES-1:0]          rate_stb;

  // Source-code register file
  always_comb begin
    wr_ok  = wr_en && ({1'b0, wr_chan} < (CHAN_W+1)'(NUM_CH));
    rd_ok  = ({1'b0, rd_chan} < (CHAN_W+1)'(NUM_CH));
    code_d = code_q;
    if (wr_ok) code_d[wr_chan] = wr_data;
    rd_data = rd_ok ? code_q[rd_chan] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  p_bad_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ok) |=> $stable(code_q));

  // Asynchronous level inputs
  ccs_sync #(.W(SYNC_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pattern_in, ext_clk_in, clk_pin_in}),
    .q     (sync_q)
  );

  assign pin_s = sync_q[NUM_CH-1:0];
  assign ext_s = sync_q[NUM_CH +: NUM_GRP];
  assign pat_s = sync_q[SYNC_W-1];

  ccs_prescaler #(
    .BASE_DIV  (BASE_DIV),
    .DECADES   (DECADES),
    .DEC_RATIO (DEC_RATIO)
  ) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_stb (rate_stb)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    for (genvar k = 0; k < CH_PER_GRP; k++) begin : g_ch
      localparam int C = g*CH_PER_GRP + k;
      localparam int P = (k > 0) ? C - 1
                       : ((g + NUM_GRP - 1) % NUM_GRP) * CH_PER_GRP + CH_PER_GRP - 1;

      ccs_chan_sel u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .code     (code_q[C]),
        .ext_mode (ext_mode),
        .rate_stb (rate_stb),
        .pin_lvl  (pin_s[C]),
        .ring_lvl (cnt_out[P]),
        .ext_lvl  (ext_s[g]),
        .pat_lvl  (pat_s),
        .clk_en   (clk_en[C]),
        .pin_oe   (clk_pin_oe[C]),
        .pin_out  (clk_pin_out[C])
      );

      p_code_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && {1'b0, wr_chan} == (CHAN_W+1)'(C)) |=> code_q[C] == $past(wr_data));

      p_pin_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q[C] != '0) |-> clk_pin_oe[C]);
    end
  end
endmodule

// File: tb/test_ccs_clk_select.sv
`timescale 1ns/1ps
module test_ccs_clk_select;
  localparam int NCH = 6;

  logic       clk, rst_n, ext_mode, wr_en, pattern_in;
  logic [2:0] wr_chan, rd_chan;
  logic [4:0] wr_data, rd_data;
  logic [5:0] clk_pin_in, cnt_out, clk_en, clk_pin_oe, clk_pin_out;
  logic [1:0] ext_clk_in;

  int n_total, n_fail;
  int cnt [NCH];

  typedef struct packed {
    logic [2:0]  ch;
    logic [4:0]  code;
    logic        ext;
    logic [16:0] win;
    logic [16:0] exp;
    logic        oe;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{3'd0, 5'd1,  1'b0, 17'd100,   17'd50, 1'b1},
    '{3'd1, 5'd2,  1'b0, 17'd200,   17'd10, 1'b1},
    '{3'd2, 5'd3,  1'b1, 17'd2000,  17'd10, 1'b1},
    '{3'd3, 5'd4,  1'b0, 17'd20000, 17'd10, 1'b1},
    '{3'd4, 5'd5,  1'b0, 17'd40000, 17'd2,  1'b1},
    '{3'd5, 5'd11, 1'b1, 17'd64,    17'd64, 1'b1},
    '{3'd5, 5'd11, 1'b0, 17'd64,    17'd0,  1'b1},
    '{3'd0, 5'd8,  1'b1, 17'd64,    17'd0,  1'b1},
    '{3'd1, 5'd9,  1'b1, 17'd64,    17'd0,  1'b1},
    '{3'd2, 5'd12, 1'b1, 17'd64,    17'd0,  1'b1},
    '{3'd3, 5'd31, 1'b1, 17'd64,    17'd0,  1'b1},
    '{3'd4, 5'd0,  1'b0, 17'd64,    17'd0,  1'b0}
  };

  ccs_clk_select i_ccs_clk_select (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .wr_en(wr_en),
    .wr_chan(wr_chan), .wr_data(wr_data), .rd_chan(rd_chan), .rd_data(rd_data),
    .clk_pin_in(clk_pin_in), .ext_clk_in(ext_clk_in), .pattern_in(pattern_in),
    .cnt_out(cnt_out), .clk_en(clk_en), .clk_pin_oe(clk_pin_oe),
    .clk_pin_out(clk_pin_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put_code(int ch, int code);
    @(negedge clk);
    wr_en = 1'b1; wr_chan = 3'(ch); wr_data = 5'(code);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic run_win(int w);
    for (int i = 0; i < NCH; i++) cnt[i] = 0;
    repeat (w) begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) if (clk_en[i]) cnt[i]++;
    end
  endtask

  function automatic string tag_of(logic [4:0] c, logic e);
    if (c == 5'd0) return "R3";
    if (c <= 5'd5) return "R5";
    if (e && c >= 5'd8 && c <= 5'd11) return "R8";
    return "R9";
  endfunction

  initial begin
    #(20ns * 190000);
    n_fail++; n_total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    n_total = 0; n_fail = 0;
    rst_n = 1'b0; ext_mode = 1'b0; wr_en = 1'b0; wr_chan = '0; wr_data = '0;
    rd_chan = '0; clk_pin_in = '0; cnt_out = '0; ext_clk_in = '0; pattern_in = 1'b0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 clk_en in reset", clk_en, 0);
    chk("R1 oe in reset", clk_pin_oe, 0);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NCH; i++) begin
      rd_chan = 3'(i); #1;
      chk("R1 code after reset", rd_data, 0);
    end
    @(negedge clk);
    chk("R1 oe after reset", clk_pin_oe, 0);
    chk("R1 clk_en after reset", clk_en, 0);

    // R2: write and read back, out-of-range index ignored
    for (int i = 0; i < NCH; i++) put_code(i, i*5 + 3);
    put_code(6, 31);
    put_code(7, 30);
    for (int i = 0; i < NCH; i++) begin
      rd_chan = 3'(i); #1;
      chk("R2 readback", rd_data, i*5 + 3);
    end
    rd_chan = 3'd6; #1;
    chk("R2 read of absent channel", rd_data, 0);

    // Vector table: rates, fixed levels, reserved codes
    foreach (TBL[v]) begin
      ext_mode = TBL[v].ext;
      put_code(TBL[v].ch, TBL[v].code);
      settle();
      chk("R4 oe for code", clk_pin_oe[TBL[v].ch], TBL[v].oe);
      run_win(TBL[v].win);
      chk(tag_of(TBL[v].code, TBL[v].ext), cnt[TBL[v].ch], TBL[v].exp);
    end

    // R6: ring of previous-channel outputs across groups
    ext_mode = 1'b0;
    put_code(0, 6); put_code(1, 6); put_code(3, 6); put_code(2, 9);
    settle();
    @(negedge clk) cnt_out[0] = 1'b1;
    run_win(8);
    chk("R6 ch1 from ch0", cnt[1], 1);
    chk("R6 ch0 not from ch0", cnt[0], 0);
    @(negedge clk) cnt_out[5] = 1'b1;
    run_win(8);
    chk("R6 ch0 from ch5 (ring wrap)", cnt[0], 1);
    chk("R6 ch1 idle", cnt[1], 0);
    @(negedge clk) cnt_out[2] = 1'b1;
    run_win(8);
    chk("R6 ch3 from ch2", cnt[3], 1);
    cnt_out = '0;

    // R7: shared external clock per group
    put_code(0, 7); put_code(3, 7); put_code(4, 7); put_code(5, 7);
    settle();
    @(negedge clk) ext_clk_in[1] = 1'b1;
    run_win(8);
    chk("R7 ch3 ext", cnt[3], 1);
    chk("R7 ch4 ext", cnt[4], 1);
    chk("R7 ch5 ext", cnt[5], 1);
    chk("R7 ch0 other group", cnt[0], 0);
    chk("R4 pin drives ext level", clk_pin_out[3], 1);
    @(negedge clk) ext_clk_in[0] = 1'b1;
    run_win(8);
    chk("R7 ch0 own group ext", cnt[0], 1);
    ext_clk_in = '0;

    // R3: own pin, edge counted once
    put_code(1, 0);
    settle();
    chk("R3 pin is input", clk_pin_oe[1], 0);
    @(negedge clk) clk_pin_in[1] = 1'b1;
    run_win(8);
    chk("R3 rising edge", cnt[1], 1);
    chk("R3 pin_out quiet", clk_pin_out[1], 0);
    run_win(8);
    chk("R3 steady level", cnt[1], 0);
    clk_pin_in = '0;

    // R8 / R9: pattern source and extended-mode gating
    ext_mode = 1'b1;
    put_code(2, 10); put_code(4, 8);
    settle();
    chk("R8 constant high on pin", clk_pin_out[4], 1);
    @(negedge clk) pattern_in = 1'b1;
    run_win(8);
    chk("R8 pattern edge", cnt[2], 1);
    chk("R8 constant high no pulses", cnt[4], 0);
    @(negedge clk) pattern_in = 1'b0;
    ext_mode = 1'b0;
    settle();
    chk("R9 code 8 low in basic mode", clk_pin_out[4], 0);
    @(negedge clk) pattern_in = 1'b1;
    run_win(8);
    chk("R9 pattern ignored in basic mode", cnt[2], 0);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule